// File: doc/BRIEF.md
# Core frequency transition controller

This block decides the clock multiplier of one two-thread processor core and walks each change through a voltage phase and a frequency phase. Each hardware thread asks for a performance level. The core's effective level is the higher of the two requests, and a thread that is idle or offline still counts toward it. A request above the highest defined level is treated as that highest level. Each level `l` maps to a multiplier `BASE_MULT + l*MULT_STEP`, where one multiplier unit is 25 MHz, and to a voltage code `VID_BASE + l*VID_STEP`.

Changes begin only at update slots, which are produced by an internal timer every `SLOT_CYC` clock cycles. A raise requests the higher voltage first and switches the multiplier once the raise time has passed. A lowering switches the multiplier and drops the voltage together at the end of the lowering time. If the requests return to the level still in force while the voltage phase is running, the transition is abandoned on the next clock edge. A request that arrives during a transition waits for the first slot after that transition has finished. The block also compares its own multiplier with those of the three other cores in its cluster and outputs the largest, which a shared cache clock can follow.

Top module: `core_freq_ctl`

## Requirements
- R1: After reset, `core_mult` equals `BASE_MULT`, which is level 0. `volt_code` equals `VID_BASE` and `busy` is low.
- R2: A transition starts only at a slot. The slot falls on the clock edge that closes every `SLOT_CYC`-th cycle after reset, so `busy` is first seen high after edge number k with k a multiple of `SLOT_CYC`. No transition starts when the effective level equals the current level.
- R3: The effective level is the larger of the two thread requests. Level l gives `core_mult` = `BASE_MULT + l*MULT_STEP` and `volt_code` = `VID_BASE + l*VID_STEP`.
- R4: A thread whose `thr_online` bit is 0 still contributes its request to the effective level.
- R5: A request above `NUM_LVLS-1` counts as `NUM_LVLS-1`. With the defaults, a request of 7 selects level 5.
- R6: A raise keeps `busy` high for exactly `UP_CYC` cycles. `core_mult` takes the new value on the edge where `busy` drops.
- R7: A lowering keeps `busy` high for exactly `DOWN_CYC` cycles. `core_mult` takes the new value on the edge where `busy` drops.
- R8: On a raise, `volt_code` moves to the target code on the edge where `busy` rises, before the multiplier changes. On a lowering, `volt_code` holds the old code until the multiplier changes, then both move together.
- R9: If the effective level returns to the current level during the voltage phase, `busy` drops on the next edge. `core_mult` stays unchanged and `volt_code` goes back to the current level's code.
- R10: A request that changes while `busy` is high does not alter the transition in progress. It starts at the first slot after completion.
- R11: `cluster_mult` is the largest of `core_mult` and all `peer_mult` entries.
- R12: `core_mult` holds its value in every cycle in which `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr0_req | input | LVL_W | Level requested by thread 0 |
| thr1_req | input | LVL_W | Level requested by thread 1 |
| thr_online | input | 2 | Online flag per thread; does not change the effective level |
| peer_mult | input | NUM_PEERS x MULT_W | Multipliers of the other cores in the cluster |
| core_mult | output | MULT_W | Multiplier in force for this core |
| busy | output | 1 | High from slot capture until the transition completes or is abandoned |
| volt_code | output | VID_W | Voltage code requested from the regulator |
| cluster_mult | output | MULT_W | Highest multiplier in the cluster |

## Verification
The bench builds the block with a 40-cycle slot, a 14-cycle raise and a 16-cycle lowering. It uses six defined levels in a 3-bit request, so the codes 6 and 7 exercise the clamp. These short timings bring several slots into a few hundred cycles. Within that span the bench can see slot alignment, both busy durations, the two voltage orderings, an abandoned transition in the middle of its voltage phase, and a request held across a lowering until the next slot.

// File: rtl/cfreq_pkg.sv
package cfreq_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_VOLT = 2'd1,
    SEQ_FREQ = 2'd2
  } seq_state_e;

  // multiplier for a level, in 25 MHz units
  function automatic int lvl_to_mult(input int lvl, input int base, input int step);
    return base + lvl * step;
  endfunction

  // voltage code for a level
  function automatic int lvl_to_vid(input int lvl, input int base, input int step);
    return base + lvl * step;
  endfunction

  // limit a requested level to the highest defined one
  function automatic int lvl_clamp(input int lvl, input int top);
    return (lvl > top) ? top : lvl;
  endfunction

endpackage

// File: rtl/slot_timer.sv
module slot_timer #(
  parameter int SLOT_CYC = 100000
) (
  input  logic clk,
  input  logic rst_n,
  output logic slot_o
);
  localparam int CW = (SLOT_CYC > 2) ? $clog2(SLOT_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(SLOT_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign slot_o = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (slot_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  AST_SLOT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    slot_o |=> !slot_o); // R2

endmodule

// File: rtl/req_merge.sv
module req_merge
  import cfreq_pkg::*;
#(
  parameter int LVL_W    = 3,
  parameter int NUM_LVLS = 6
) (
  input  logic [LVL_W-1:0] req0_i,
  input  logic [LVL_W-1:0] req1_i,
  input  logic [1:0]       online_i,
  output logic [LVL_W-1:0] eff_o
);
  localparam int TOP = NUM_LVLS - 1;

  logic [1:0][LVL_W-1:0] raw;
  logic [1:0][LVL_W-1:0] clamped;

  assign raw[0] = req0_i;
  assign raw[1] = req1_i;

  for (genvar g = 0; g < 2; g++) begin : g_thr
    assign clamped[g] = LVL_W'(lvl_clamp(int'(raw[g]), TOP));
  end

  // offline threads are not masked: every request competes
  assign eff_o = (clamped[0] > clamped[1]) ? clamped[0] : clamped[1];

  always_comb begin
    AST_OFFLINE_T0_COUNTS: assert (online_i[0] || (eff_o >= clamped[0])); // R4
    AST_OFFLINE_T1_COUNTS: assert (online_i[1] || (eff_o >= clamped[1])); // R4
    AST_EFF_IN_RANGE: assert (int'(eff_o) <= TOP); // R5
  end

endmodule

// File: rtl/xition_seq.sv
module xition_seq
  import cfreq_pkg::*;
#(
  parameter int LVL_W     = 3,
  parameter int MULT_W    = 8,
  parameter int VID_W     = 8,
  parameter int BASE_MULT = 60,
  parameter int MULT_STEP = 8,
  parameter int VID_BASE  = 32,
  parameter int VID_STEP  = 4,
  parameter int UP_CYC    = 36000,
  parameter int DOWN_CYC  = 39000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_i,
  input  logic [LVL_W-1:0]  eff_lvl_i,
  output logic [MULT_W-1:0] mult_o,
  output logic [VID_W-1:0]  vid_o,
  output logic              busy_o
);
  localparam int MAXD = (UP_CYC > DOWN_CYC) ? UP_CYC : DOWN_CYC;
  localparam int TW   = (MAXD > 2) ? $clog2(MAXD) : 1;
  localparam logic [TW-1:0] UP_LOAD   = TW'(UP_CYC - 2);
  localparam logic [TW-1:0] DOWN_LOAD = TW'(DOWN_CYC - 2);

  seq_state_e        st_q;
  logic [LVL_W-1:0]  cur_q, tgt_q;
  logic [TW-1:0]     tmr_q;
  logic [MULT_W-1:0] mult_q;
  logic [VID_W-1:0]  vid_q;

  // named events for the checks below
  logic going_up, capture_evt, revert_hit, volt_done, commit_evt;
  assign going_up    = eff_lvl_i > cur_q;
  assign capture_evt = (st_q == SEQ_IDLE) && slot_i && (eff_lvl_i != cur_q);
  assign revert_hit  = (st_q == SEQ_VOLT) && (eff_lvl_i == cur_q);
  assign volt_done   = (st_q == SEQ_VOLT) && !revert_hit && (tmr_q == '0);
  assign commit_evt  = (st_q == SEQ_FREQ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      cur_q  <= '0;
      tgt_q  <= '0;
      tmr_q  <= '0;
      mult_q <= MULT_W'(lvl_to_mult(0, BASE_MULT, MULT_STEP));
      vid_q  <= VID_W'(lvl_to_vid(0, VID_BASE, VID_STEP));
    end else begin
      unique case (st_q)
        SEQ_IDLE: begin
          if (capture_evt) begin
            st_q  <= SEQ_VOLT;
            tgt_q <= eff_lvl_i;
            tmr_q <= going_up ? UP_LOAD : DOWN_LOAD;
            if (going_up) vid_q <= VID_W'(lvl_to_vid(int'(eff_lvl_i), VID_BASE, VID_STEP));
          end
        end
        SEQ_VOLT: begin
          if (revert_hit) begin
            st_q  <= SEQ_IDLE;
            vid_q <= VID_W'(lvl_to_vid(int'(cur_q), VID_BASE, VID_STEP));
          end else if (volt_done) begin
            st_q <= SEQ_FREQ;
          end else begin
            tmr_q <= tmr_q - 1'b1;
          end
        end
        SEQ_FREQ: begin
          st_q   <= SEQ_IDLE;
          cur_q  <= tgt_q;
          mult_q <= MULT_W'(lvl_to_mult(int'(tgt_q), BASE_MULT, MULT_STEP));
          vid_q  <= VID_W'(lvl_to_vid(int'(tgt_q), VID_BASE, VID_STEP));
        end
        default: st_q <= SEQ_IDLE;
      endcase
    end
  end

  assign mult_o = mult_q;
  assign vid_o  = vid_q;
  assign busy_o = (st_q != SEQ_IDLE);

  AST_BUSY_AT_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(slot_i)); // R2
  AST_MULT_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> $stable(mult_o)); // R12
  AST_RAISE_VID_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    (mult_o > $past(mult_o)) |-> $stable(vid_o)); // R8
  AST_LOWER_VID_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    (mult_o < $past(mult_o)) |-> (vid_o < $past(vid_o))); // R8
  AST_REVERT_QUICK: assert property (@(posedge clk) disable iff (!rst_n)
    revert_hit |=> (!busy_o && $stable(mult_o))); // R9
  AST_COMMIT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> !busy_o); // R6

endmodule

// File: rtl/core_freq_ctl.sv
module core_freq_ctl #(
  parameter int LVL_W     = 3,
  parameter int NUM_LVLS  = 6,
  parameter int MULT_W    = 8,
  parameter int VID_W     = 8,
  parameter int BASE_MULT = 60,
  parameter int MULT_STEP = 8,
  parameter int VID_BASE  = 32,
  parameter int VID_STEP  = 4,
  parameter int SLOT_CYC  = 100000,
  parameter int UP_CYC    = 36000,
  parameter int DOWN_CYC  = 39000,
  parameter int NUM_PEERS = 3
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [LVL_W-1:0]                 thr0_req,
  input  logic [LVL_W-1:0]                 thr1_req,
  input  logic [1:0]                       thr_online,
  input  logic [NUM_PEERS-1:0][MULT_W-1:0] peer_mult,
  output logic [MULT_W-1:0]                core_mult,
  output logic                             busy,
  output logic [VID_W-1:0]                 volt_code,
  output logic [MULT_W-1:0]                cluster_mult
);
  logic             slot_evt;
  logic [LVL_W-1:0] eff_lvl;

  slot_timer #(.SLOT_CYC(SLOT_CYC)) u_slot (
    .clk    (clk),
    .rst_n  (rst_n),
    .slot_o (slot_evt)
  );

  req_merge #(.LVL_W(LVL_W), .NUM_LVLS(NUM_LVLS)) u_merge (
    .req0_i   (thr0_req),
    .req1_i   (thr1_req),
    .online_i (thr_online),
    .eff_o    (eff_lvl)
  );

  xition_seq #(
    .LVL_W(LVL_W), .MULT_W(MULT_W), .VID_W(VID_W),
    .BASE_MULT(BASE_MULT), .MULT_STEP(MULT_STEP),
    .VID_BASE(VID_BASE), .VID_STEP(VID_STEP),
    .UP_CYC(UP_CYC), .DOWN_CYC(DOWN_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_i    (slot_evt),
    .eff_lvl_i (eff_lvl),
    .mult_o    (core_mult),
    .vid_o     (volt_code),
    .busy_o    (busy)
  );

  // running maximum across the cluster
  logic [MULT_W-1:0] run_max [NUM_PEERS+1];
  assign run_max[0] = core_mult;
  for (genvar g = 0; g < NUM_PEERS; g++) begin : g_peer
    assign run_max[g+1] = (peer_mult[g] > run_max[g]) ? peer_mult[g] : run_max[g];
  end
  assign cluster_mult = run_max[NUM_PEERS];

  AST_CLUSTER_COVERS_CORE: assert property (@(posedge clk) disable iff (!rst_n)
    cluster_mult >= core_mult); // R11

endmodule

// File: tb/sim_core_freq_ctl.sv
module sim_core_freq_ctl;
  localparam int SLOT = 40;
  localparam int UP   = 14;
  localparam int DOWN = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] r0 = '0, r1 = '0;
  logic [1:0] onl = 2'b11;
  logic [2:0][7:0] peers;
  logic [7:0] core_mult, volt_code, cluster_mult;
  logic busy;

  int total = 0, bad = 0, cyc = 0, cur_lvl = 0;

  always #5 clk = ~clk;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  core_freq_ctl #(
    .LVL_W(3), .NUM_LVLS(6), .MULT_W(8), .VID_W(8),
    .BASE_MULT(60), .MULT_STEP(8), .VID_BASE(32), .VID_STEP(4),
    .SLOT_CYC(SLOT), .UP_CYC(UP), .DOWN_CYC(DOWN), .NUM_PEERS(3)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .thr0_req(r0), .thr1_req(r1),
    .thr_online(onl), .peer_mult(peers), .core_mult(core_mult),
    .busy(busy), .volt_code(volt_code), .cluster_mult(cluster_mult)
  );

  function automatic int em(input int l); return 60 + 8 * l; endfunction
  function automatic int ev(input int l); return 32 + 4 * l; endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // drive requests, wait for a slot capture, then follow the transition
  task automatic move(input int a, input int b, input logic [1:0] on, input int tl,
                      input string tag, output int k_o);
    int n = 0;
    int d = 1;
    bit held = 1'b1;
    bit up;
    @(negedge clk);
    r0 = 3'(a); r1 = 3'(b); onl = on;
    while (!busy && n < 3 * SLOT) begin @(negedge clk); n++; end
    k_o = cyc;
    chk(busy, tag, "busy never rose", int'(busy), 1);
    if (!busy) return;
    up = tl > cur_lvl;
    chk(k_o % SLOT == 0, "R2", "capture edge mod slot", k_o % SLOT, 0);
    chk(volt_code == 8'(up ? ev(tl) : ev(cur_lvl)), "R8", "vid at capture",
        int'(volt_code), up ? ev(tl) : ev(cur_lvl));
    while (busy && d < 2 * SLOT) begin
      if (core_mult != 8'(em(cur_lvl))) held = 1'b0;
      @(negedge clk);
      if (busy) d++;
    end
    chk(held, "R12", "mult moved while busy", int'(core_mult), em(cur_lvl));
    chk(d == (up ? UP : DOWN), up ? "R6" : "R7", "busy length", d, up ? UP : DOWN);
    chk(core_mult == 8'(em(tl)), tag, "mult after move", int'(core_mult), em(tl));
    chk(volt_code == 8'(ev(tl)), "R8", "vid after move", int'(volt_code), ev(tl));
    cur_lvl = tl;
  endtask

  task automatic t_reset;
    peers[0] = 8'd70; peers[1] = 8'd50; peers[2] = 8'd64;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(core_mult == 8'd60, "R1", "reset mult", int'(core_mult), 60);
    chk(volt_code == 8'd32, "R1", "reset vid", int'(volt_code), 32);
    chk(!busy, "R1", "reset busy", int'(busy), 0);
    chk(cluster_mult == 8'd70, "R11", "cluster with peer ahead", int'(cluster_mult), 70);
  endtask

  task automatic t_max_and_offline;
    int k;
    move(3, 0, 2'b11, 3, "R3", k);
    chk(cluster_mult == 8'd84, "R11", "cluster follows core", int'(cluster_mult), 84);
    move(1, 4, 2'b01, 4, "R4", k);
    move(1, 1, 2'b11, 1, "R7", k);
  endtask

  task automatic t_clamp;
    int k;
    move(7, 2, 2'b11, 5, "R5", k);
    chk(cluster_mult == 8'd100, "R11", "cluster at top level", int'(cluster_mult), 100);
  endtask

  task automatic t_revert;
    int n = 0;
    bit quiet = 1'b1;
    @(negedge clk);
    r0 = 3'd2; r1 = 3'd2;
    while (!busy && n < 3 * SLOT) begin @(negedge clk); n++; end
    chk(busy, "R9", "lowering began", int'(busy), 1);
    chk(volt_code == 8'(ev(5)), "R8", "vid held on lowering", int'(volt_code), ev(5));
    repeat (3) @(negedge clk);
    r0 = 3'd5; r1 = 3'd5;
    @(negedge clk);
    chk(!busy, "R9", "busy after revert", int'(busy), 0);
    chk(core_mult == 8'(em(5)), "R9", "mult after revert", int'(core_mult), em(5));
    chk(volt_code == 8'(ev(5)), "R9", "vid after revert", int'(volt_code), ev(5));
    repeat (2 * SLOT) begin
      @(negedge clk);
      if (busy) quiet = 1'b0;
    end
    chk(quiet, "R2", "no capture when level unchanged", int'(quiet), 1);
  endtask

  task automatic t_held;
    int k1, k2;
    int n = 0;
    int d = 1;
    @(negedge clk);
    r0 = 3'd0; r1 = 3'd0;
    while (!busy && n < 3 * SLOT) begin @(negedge clk); n++; end
    k1 = cyc;
    @(negedge clk);
    r0 = 3'd3;
    while (busy && d < 2 * SLOT) begin @(negedge clk); if (busy) d++; end
    chk(d == DOWN - 1, "R10", "late request left lowering length", d + 1, DOWN);
    chk(core_mult == 8'(em(0)), "R10", "in-flight target kept", int'(core_mult), em(0));
    cur_lvl = 0;
    move(3, 0, 2'b11, 3, "R10", k2);
    chk(k2 == k1 + SLOT, "R10", "held request slot", k2, k1 + SLOT);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    total++; bad++;
    $display("FAIL R2 watchdog expired actual=%0d expected=done", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    peers = '0;
    t_reset();
    t_max_and_offline();
    t_clamp();
    t_revert();
    t_held();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule